// File: doc/BRIEF.md
# Two-Edge Delay-Line Timestamp Decoder

This block turns the sampled state of a tapped delay line into a timestamp, one word per hit. Each hit sends a short pulse into the chain. That pulse has one rising and one falling boundary, so a single snapshot taken on the sampling clock edge holds two transitions. A plain single-edge decoder would only find one of them.

The block cleans isolated bubbles from the snapshot with a three-tap majority vote. It then finds the nearest transition to the chain input and the nearest transition after that one. It adds the two tap positions to form a fine time one bit wider than a single position. This roughly halves the average bin and splits the ultra-wide bins. The result is joined with the coarse clock count taken on the same edge. The fine time counts tap positions relative to the sampling edge. A hit that does not show two transitions is reported with an error flag.

A small state machine in the state `wu_state_t` holds the outcome of the last sampled cycle:

- `ST_IDLE` means no hit was sampled.
- `ST_STAMP` means a hit with two transitions was sampled.
- `ST_FAULT` means a hit with fewer than two transitions was sampled.

On every clock the machine moves as follows:

- Any state goes to `ST_STAMP` when `hit_vld` is high and both transitions are found.
- Any state goes to `ST_FAULT` when `hit_vld` is high and fewer than two transitions are found.
- Any state goes to `ST_IDLE` when `hit_vld` is low.

Top module: `wu_tdc_decoder`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it, the block is in `ST_IDLE`, `ts_vld` and `ts_err` are 0, and `ts_word` is all zeros.
- R2: `ts_vld` is high exactly in the cycle after a cycle where `hit_vld` was high at the clock edge. When `ts_vld` is low, `ts_word` is zero, and snapshot contents have no effect.
- R3: The upper CW bits of `ts_word` equal the `coarse` value sampled on the hit's clock edge.
- R4: A transition at position i (0 to TAPS-2) means filtered bit i differs from filtered bit i+1. Bit 0 is the chain input end. The first transition is the lowest such i.
- R5: The second transition is the lowest position strictly above the first one. Any later transitions are ignored.
- R6: On a good hit, the low PW+1 bits of `ts_word` hold the unsigned sum of the two positions, where PW = clog2(TAPS). `ts_err` is 0.
- R7: If the filtered snapshot shows fewer than two transitions, then `ts_vld` and `ts_err` are 1, the fine field is zero, and the coarse field still follows R3.
- R8: Before the search, each interior bit is replaced by the majority of itself and its two neighbours. Bits 0 and TAPS-1 pass through unchanged.
- R9: `ts_err` is never high unless `ts_vld` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, also the timing reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_vld | input | 1 | Snapshot in this cycle belongs to a hit |
| snap | input | TAPS | Delay-line snapshot, bit 0 at the chain input |
| coarse | input | CW | Coarse clock count |
| ts_vld | output | 1 | Timestamp word valid |
| ts_err | output | 1 | Fewer than two transitions found |
| ts_word | output | CW+PW+1 | {coarse, summed fine position} |

## Verification
The bench targets several corner cases, each of which exposes a specific design fault:

- Hits whose pulse touches tap 0 or the top tap would show an off-by-one in the search boundaries. A design with such an error would report a sum shifted by one or a spurious error.
- Snapshots with three or four transitions would show whether the second search really starts just past the first. A design that does not would pick a later edge and report too large a sum.
- Bubbles inside a pulse, before it, or standing alone test the majority filter. Without the filter the sum would be wrong, or an error would be reported for a good hit. A filter that also rewrote the end taps would lose an edge at tap 0.
- Single steps, empty lines and back-to-back hits with changing coarse counts check three things: the error path, that the coarse count is taken on the hit's own edge, and that a dropped hit strobe yields no word.

// File: rtl/wu_tdc_pkg.sv
package wu_tdc_pkg;
    // Outcome of the previous sampled cycle
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STAMP = 2'd1,
        ST_FAULT = 2'd2
    } wu_state_t;
endpackage

// File: rtl/wu_bubble_filter.sv
module wu_bubble_filter #(
    parameter int TAPS = 32
) (
    input  logic [TAPS-1:0] raw,
    output logic [TAPS-1:0] clean
);
    // Three-tap majority on interior bits; end taps pass through
    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        if (i == 0 || i == TAPS - 1) begin : g_end
            assign clean[i] = raw[i];
        end else begin : g_mid
            assign clean[i] = (raw[i-1] & raw[i]) | (raw[i] & raw[i+1])
                            | (raw[i-1] & raw[i+1]);
        end
    end
endmodule

// File: rtl/wu_edge_seek.sv
module wu_edge_seek #(
    parameter int TAPS = 32,
    parameter int PW   = $clog2(TAPS)
) (
    input  logic [TAPS-1:0] line,
    input  logic [PW-1:0]   from_pos,
    output logic            found,
    output logic [PW-1:0]   pos
);
    // Priority search: lowest index at or above from_pos where neighbours differ
    always_comb begin
        found = 1'b0;
        pos   = '0;
        for (int i = TAPS - 2; i >= 0; i--) begin
            if (i >= int'(from_pos) && (line[i] != line[i+1])) begin
                found = 1'b1;
                pos   = PW'(i);
            end
        end
    end
endmodule

// File: rtl/wu_tdc_decoder.sv
module wu_tdc_decoder
    import wu_tdc_pkg::*;
#(
    parameter int TAPS = 32,
    parameter int CW   = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               hit_vld,
    input  logic [TAPS-1:0]                    snap,
    input  logic [CW-1:0]                      coarse,
    output logic                               ts_vld,
    output logic                               ts_err,
    output logic [CW+$clog2(TAPS)+1-1:0]       ts_word
);
    localparam int PW = $clog2(TAPS);
    localparam int FW = PW + 1;
    localparam int OW = CW + FW;

    logic [TAPS-1:0] clean;
    logic            fnd_a, fnd_b;
    logic [PW-1:0]   pos_a, pos_b, from_b;
    logic [FW-1:0]   fine_sum;

    wu_state_t       st_q, st_d;
    logic [CW-1:0]   coarse_q;
    logic [FW-1:0]   fine_q;

    wu_bubble_filter #(.TAPS(TAPS)) u_filt (
        .raw   (snap),
        .clean (clean)
    );

    wu_edge_seek #(.TAPS(TAPS), .PW(PW)) u_seek_a (
        .line     (clean),
        .from_pos ('0),
        .found    (fnd_a),
        .pos      (pos_a)
    );

    assign from_b = pos_a + PW'(1);

    wu_edge_seek #(.TAPS(TAPS), .PW(PW)) u_seek_b (
        .line     (clean),
        .from_pos (from_b),
        .found    (fnd_b),
        .pos      (pos_b)
    );

    // Sum keeps the half-position that an average would drop
    assign fine_sum = FW'(pos_a) + FW'(pos_b);

    always_comb begin
        if (!hit_vld)
            st_d = ST_IDLE;
        else if (fnd_a && fnd_b)
            st_d = ST_STAMP;
        else
            st_d = ST_FAULT;
    end

    // State register and captured fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            coarse_q <= '0;
            fine_q   <= '0;
        end else begin
            st_q <= st_d;
            if (hit_vld) begin
                coarse_q <= coarse;
                fine_q   <= fine_sum;
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        ts_vld  = 1'b0;
        ts_err  = 1'b0;
        ts_word = '0;
        unique case (st_q)
            ST_IDLE: begin
                ts_vld  = 1'b0;
            end
            ST_STAMP: begin
                ts_vld  = 1'b1;
                ts_word = {coarse_q, fine_q};
            end
            ST_FAULT: begin
                ts_vld  = 1'b1;
                ts_err  = 1'b1;
                ts_word = {coarse_q, {FW{1'b0}}};
            end
            default: begin
                ts_vld  = 1'b0;
            end
        endcase
    end

    logic unused_ok;
    assign unused_ok = ^{OW'(0)};
endmodule

// File: rtl/wu_tdc_checker.sv
module wu_tdc_checker #(
    parameter int TAPS = 32,
    parameter int CW   = 16
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          hit_vld,
    input logic [CW-1:0]                 coarse,
    input logic                          ts_vld,
    input logic                          ts_err,
    input logic [CW+$clog2(TAPS)+1-1:0]  ts_word
);
    localparam int PW = $clog2(TAPS);
    localparam int FW = PW + 1;
    localparam int OW = CW + FW;
    localparam logic [FW-1:0] FINE_MAX = FW'(2 * TAPS - 5);

    p_vld_after_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_vld |=> ts_vld);
    p_quiet_without_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_vld |=> !ts_vld);
    p_idle_word_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_vld |-> ts_word == '0);
    p_coarse_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_vld |=> ts_word[OW-1:FW] == $past(coarse));
    p_fault_fine_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ts_err |-> ts_word[FW-1:0] == '0);
    p_fault_needs_vld_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ts_err |-> ts_vld);
    p_sum_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_vld && !ts_err) |-> (ts_word[FW-1:0] >= FW'(1)
                                 && ts_word[FW-1:0] <= FINE_MAX));
endmodule

bind wu_tdc_decoder wu_tdc_checker #(.TAPS(TAPS), .CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_vld (hit_vld),
    .coarse  (coarse),
    .ts_vld  (ts_vld),
    .ts_err  (ts_err),
    .ts_word (ts_word)
);

// File: tb/sim_wu_tdc_decoder.sv
module sim_wu_tdc_decoder;
    localparam int CLK_P = 10;
    localparam int TAPS  = 32;
    localparam int CW    = 16;
    localparam int FW    = $clog2(TAPS) + 1;
    localparam int OW    = CW + FW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            hit_vld = 1'b0;
    logic [TAPS-1:0] snap = '0;
    logic [CW-1:0]   coarse = '0;
    logic            ts_vld, ts_err;
    logic [OW-1:0]   ts_word;

    int n_cmp = 0;
    int n_bad = 0;

    logic          e_vld = 1'b0;
    logic          e_err = 1'b0;
    logic [OW-1:0] e_word = '0;
    string         e_tag = "R1";

    always #(CLK_P/2) clk = ~clk;

    wu_tdc_decoder #(.TAPS(TAPS), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .hit_vld(hit_vld), .snap(snap),
        .coarse(coarse), .ts_vld(ts_vld), .ts_err(ts_err), .ts_word(ts_word)
    );

    function automatic logic [TAPS-1:0] band(input int lo, input int hi);
        logic [TAPS-1:0] v = '0;
        for (int i = lo; i <= hi; i++) v[i] = 1'b1;
        return v;
    endfunction

    // Behavioural reference: vote, then two scans
    function automatic void ref_model(input logic [TAPS-1:0] s, output int sum, output bit bad);
        int f[TAPS];
        int p1 = -1;
        int p2 = -1;
        for (int i = 0; i < TAPS; i++) begin
            if (i == 0 || i == TAPS - 1) f[i] = int'(s[i]);
            else f[i] = (int'(s[i-1]) + int'(s[i]) + int'(s[i+1]) >= 2) ? 1 : 0;
        end
        for (int i = 0; i < TAPS - 1; i++)
            if (p1 < 0 && f[i] != f[i+1]) p1 = i;
        if (p1 >= 0)
            for (int i = p1 + 1; i < TAPS - 1; i++)
                if (p2 < 0 && f[i] != f[i+1]) p2 = i;
        bad = (p2 < 0);
        sum = bad ? 0 : p1 + p2;
    endfunction

    task automatic compare();
        n_cmp++;
        if (ts_vld !== e_vld || ts_err !== e_err || ts_word !== e_word) begin
            n_bad++;
            $display("FAIL %s actual vld=%0b err=%0b word=%h expected vld=%0b err=%0b word=%h",
                     e_tag, ts_vld, ts_err, ts_word, e_vld, e_err, e_word);
        end
    endtask

    task automatic step(input bit h, input logic [TAPS-1:0] s, input logic [CW-1:0] c,
                        input string tag);
        int  sm;
        bit  bd;
        @(negedge clk);
        compare();
        hit_vld = h;
        snap    = s;
        coarse  = c;
        ref_model(s, sm, bd);
        e_tag = tag;
        e_vld = h;
        e_err = h && bd;
        e_word = h ? {c, FW'(sm)} : '0;
    endtask

    initial begin
        #(CLK_P * 100000);
        n_bad++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: outputs idle during reset
        repeat (3) @(negedge clk);
        compare();
        snap = band(3, 9);
        hit_vld = 1'b1;
        @(negedge clk);
        compare();
        hit_vld = 1'b0;
        rst_n = 1'b1;
        e_tag = "R1";

        step(1, band(3, 7), 16'h0101, "R4");
        step(1, band(1, 2), 16'h0102, "R4");
        step(1, '0, 16'h0103, "R7");
        step(1, band(0, 9), 16'h0104, "R7");
        step(1, band(0, 0), 16'h0105, "R7");
        step(1, band(28, 31), 16'h0106, "R7");
        step(1, band(29, 30), 16'h0107, "R6");
        step(1, band(4, 12) & ~band(8, 8), 16'h0108, "R8");
        step(1, band(20, 20), 16'h0109, "R8");
        step(1, band(2, 2) | band(10, 14), 16'h010A, "R8");
        step(1, band(5, 6) | band(15, 20), 16'h010B, "R5");
        step(1, band(0, 1) | band(6, 6) | band(9, 12), 16'h010C, "R5");
        step(0, band(3, 7), 16'h010D, "R2");
        step(1, band(7, 11), 16'hAAAA, "R3");
        step(1, band(8, 12), 16'h5555, "R3");
        step(0, '0, 16'h0000, "R9");
        for (int k = 0; k < 400; k++) begin
            int lo = int'($urandom_range(0, TAPS - 2));
            int hi = int'($urandom_range(lo, TAPS - 1));
            logic [TAPS-1:0] s = ($urandom_range(0, 3) == 0) ? TAPS'($urandom) : band(lo, hi);
            step(bit'($urandom_range(0, 3) != 0), s, CW'($urandom), "R6");
        end
        step(0, '0, '0, "R2");
        @(negedge clk);
        compare();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule